// File: doc/BRIEF.md
# Big-Endian Byte-Lane Steering Unit

This block sits between a processor's internal 32-bit operand register and a 32-bit external data bus. For each transfer it decides which of the four byte lanes take part and drives one active-low strobe per lane. On the write side it places the operand bytes on those lanes. On the read side it gathers the same lanes back into a right-justified operand, which is captured in a register when the bus acknowledges the data. Lanes are numbered big-endian: lane 0 is data bits 31..24 and carries the most significant operand byte.

Two modes select the lanes. In size mode, a 2-bit transfer-size code and the two low address bits pick a byte, word, long-word or line placement. Any byte or word can sit at any offset that fits inside the long word, including a word that straddles the middle two lanes. In mask mode, a caller-supplied active-low lane mask selects the lanes directly and each byte keeps its natural position. An operand that would cross into the next long word is not split. It is flagged as an error instead.

Top module: `lane_steer`

## Requirements
- R1: With `xfer_act` high, `use_mask` low and size code 00 (long word), all four strobes are low and `bus_wr` equals `wr_operand` unchanged. Operand bits 31..24 appear on lane 0, and `lane_stb_n[k]` is the strobe of the lane at data bits 31-8k..24-8k.
- R2: Size code 11 (line) behaves exactly like a long word. For both codes, `addr_lo` has no effect on strobes, write data or read data.
- R3: Size code 01 (byte) at offset n drives only `lane_stb_n[n]` low and places `wr_operand[7:0]` on lane n. All other lanes of `bus_wr` are zero.
- R4: Size code 10 (word) at offset 0 drives strobes 0 and 1 low, with `wr_operand[15:0]` on bits 31..16. At offset 2 it drives strobes 2 and 3 low, with the word on bits 15..0.
- R5: A word at offset 1 drives strobes 1 and 2 low and places `wr_operand[15:0]` on bits 23..8.
- R6: A word at offset 3 raises `size_err`, leaves all strobes high and drives `bus_wr` to zero. If such a read is acknowledged, it loads zero into `rd_operand`.
- R7: While `xfer_act` is low, all strobes are high, `size_err` is low and `bus_wr` is zero.
- R8: On an acknowledged read in size mode, the captured operand holds the selected lane bytes right-justified, in big-endian order, with unused upper bytes zero. A long word or line is taken whole.
- R9: `rd_operand` loads only on a rising clock edge at which `ack`, `xfer_act` and read direction (`xfer_wr` low) are all high. At every other edge it holds, including when `ack` comes during a write or while idle.
- R10: A synchronous active-high `rst` clears `rd_operand` to zero on the next rising edge.
- R11: With `use_mask` high, the strobes equal `lane_mask_n` while active, and the size code and `addr_lo` are ignored. `bus_wr` carries the operand's own bytes on the selected lanes and zero elsewhere. A read captures the bus with unselected lanes zeroed, without shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| xfer_act | input | 1 | A transfer is in progress |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| size_code | input | 2 | 00 long, 01 byte, 10 word, 11 line |
| addr_lo | input | 2 | Byte offset within the long word |
| use_mask | input | 1 | 1 = lanes taken from `lane_mask_n` |
| lane_mask_n | input | 4 | Requested lanes, active low, bit k = lane k |
| wr_operand | input | 32 | Right-justified write operand |
| bus_rd | input | 32 | Data arriving from the external bus |
| ack | input | 1 | Data-valid acknowledge |
| bus_wr | output | 32 | Steered data toward the external bus |
| lane_stb_n | output | 4 | Active-low lane strobes, bit k = lane k |
| size_err | output | 1 | Word placement runs past lane 3 |
| rd_operand | output | 32 | Registered, right-justified read operand |

## Verification
Writes are issued with a distinct byte value in every operand byte at each of the four offsets for every size code, so a byte landing on the wrong lane, or in swapped order, shows up as a wrong value. Long and line transfers are repeated at nonzero offsets to show that the address is ignored. Reads use bus words whose four bytes all differ, which separates a right shift from a mirror and shows missing zero fill. Acknowledges are also given during writes, while idle and on the faulty word offset, and a mask with gaps is applied to show that mask mode neither shifts nor leaks unselected lanes.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int SPAN_W = OFF_W + 1;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    // Placement chosen for one transfer: which lanes are live, where the
    // operand starts, how many bytes it spans and whether it overflows.
    typedef struct packed {
        logic [LANES-1:0]  en;
        logic [OFF_W-1:0]  first;
        logic [SPAN_W-1:0] span;
        logic              err;
    } lane_plan_t;

    function automatic logic [SPAN_W-1:0] span_of(xfer_size_e sz);
        case (sz)
            SZ_BYTE: span_of = SPAN_W'(1);
            SZ_WORD: span_of = SPAN_W'(2);
            default: span_of = SPAN_W'(LANES);
        endcase
    endfunction

    // Byte idx counted from the least significant end of v.
    function automatic logic [BYTE_W-1:0] get_byte(logic [DATA_W-1:0] v, int idx);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k == idx) r = v[k*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lane_planner.sv
module lane_planner
    import lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_act,
    input  logic             use_mask,
    input  logic [LANES-1:0] mask_n,
    input  xfer_size_e       size,
    input  logic [OFF_W-1:0] offs,
    output lane_plan_t       plan
);

    always_comb begin
        int f;
        int s;
        int e;
        plan = '0;
        s = int'(span_of(size));
        f = (size == SZ_LONG || size == SZ_LINE) ? 0 : int'(offs);
        e = f + s;
        if (use_mask) begin
            plan.first = '0;
            plan.span  = SPAN_W'(LANES);
            plan.en    = xfer_act ? ~mask_n : '0;
        end else begin
            plan.first = OFF_W'(f);
            plan.span  = SPAN_W'(s);
            plan.err   = xfer_act && (e > LANES);
            for (int l = 0; l < LANES; l++) begin
                plan.en[l] = xfer_act && (e <= LANES) && (l >= f) && (l < e);
            end
        end
    end

    // R6
    err_only_bad_word_chk: assert property (@(posedge clk) disable iff (rst)
        plan.err |-> (size == SZ_WORD && offs == '1 && !use_mask && xfer_act));

    // R2
    wide_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_act && !use_mask && (size == SZ_LONG || size == SZ_LINE)) |-> plan.en == '1);

    // R3
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_act && !use_mask && size == SZ_BYTE) |-> $countones(plan.en) == 1);

endmodule

// File: rtl/lane_write_mux.sv
module lane_write_mux
    import lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_plan_t        plan,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] bus
);

    // Lane l sits at bits (LANES-1-l)*BYTE_W; it takes the operand byte
    // whose big-endian rank inside the transfer matches its lane.
    always_comb begin
        bus = '0;
        for (int l = 0; l < LANES; l++) begin
            if (plan.en[l]) begin
                bus[(LANES-1-l)*BYTE_W +: BYTE_W] =
                    get_byte(operand, int'(plan.first) + int'(plan.span) - 1 - l);
            end
        end
    end

    // R6
    err_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        plan.err |-> bus == '0);

endmodule

// File: rtl/lane_read_mux.sv
module lane_read_mux
    import lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_plan_t        plan,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] ext
);

    // Operand byte j (from the low end) comes from lane first+span-1-j.
    always_comb begin
        int lane;
        ext = '0;
        for (int j = 0; j < LANES; j++) begin
            lane = int'(plan.first) + int'(plan.span) - 1 - j;
            if (j < int'(plan.span) && lane >= 0 && lane < LANES) begin
                if (plan.en[lane]) begin
                    ext[j*BYTE_W +: BYTE_W] = get_byte(bus, LANES - 1 - lane);
                end
            end
        end
    end

    // R8
    byte_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (plan.span == SPAN_W'(1)) |-> ext[DATA_W-1:BYTE_W] == '0);

    // R6
    err_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        plan.err |-> ext == '0);

endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_act,
    input  logic        xfer_wr,
    input  logic [1:0]  size_code,
    input  logic [1:0]  addr_lo,
    input  logic        use_mask,
    input  logic [3:0]  lane_mask_n,
    input  logic [31:0] wr_operand,
    input  logic [31:0] bus_rd,
    input  logic        ack,
    output logic [31:0] bus_wr,
    output logic [3:0]  lane_stb_n,
    output logic        size_err,
    output logic [31:0] rd_operand
);

    lane_plan_t        plan;
    logic [DATA_W-1:0] rd_next;
    logic              rd_take;

    lane_planner u_planner (
        .clk      (clk),
        .rst      (rst),
        .xfer_act (xfer_act),
        .use_mask (use_mask),
        .mask_n   (lane_mask_n),
        .size     (xfer_size_e'(size_code)),
        .offs     (addr_lo),
        .plan     (plan)
    );

    lane_write_mux u_wmux (
        .clk     (clk),
        .rst     (rst),
        .plan    (plan),
        .operand (wr_operand),
        .bus     (bus_wr)
    );

    lane_read_mux u_rmux (
        .clk  (clk),
        .rst  (rst),
        .plan (plan),
        .bus  (bus_rd),
        .ext  (rd_next)
    );

    assign lane_stb_n = ~plan.en;
    assign size_err   = plan.err;
    assign rd_take    = xfer_act && !xfer_wr && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_operand <= '0;
        end else if (rd_take) begin
            rd_operand <= rd_next;
        end
    end

    // R7
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_act |-> (lane_stb_n == '1 && !size_err && bus_wr == '0));

    // R6
    err_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        size_err |-> lane_stb_n == '1);

    // R9
    hold_operand_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_act && !xfer_wr && ack) |=> $stable(rd_operand));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> rd_operand == '0);

endmodule

// File: tb/lane_steer_bench.sv
`timescale 1ns/1ps
module lane_steer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_act = 1'b0;
    logic        xfer_wr = 1'b0;
    logic [1:0]  size_code = 2'b00;
    logic [1:0]  addr_lo = 2'b00;
    logic        use_mask = 1'b0;
    logic [3:0]  lane_mask_n = 4'hF;
    logic [31:0] wr_operand = '0;
    logic [31:0] bus_rd = '0;
    logic        ack = 1'b0;
    logic [31:0] bus_wr;
    logic [3:0]  lane_stb_n;
    logic        size_err;
    logic [31:0] rd_operand;

    always #10 clk = ~clk;

    lane_steer u_lane_steer (
        .clk(clk), .rst(rst), .xfer_act(xfer_act), .xfer_wr(xfer_wr),
        .size_code(size_code), .addr_lo(addr_lo), .use_mask(use_mask),
        .lane_mask_n(lane_mask_n), .wr_operand(wr_operand), .bus_rd(bus_rd),
        .ack(ack), .bus_wr(bus_wr), .lane_stb_n(lane_stb_n),
        .size_err(size_err), .rd_operand(rd_operand)
    );

    typedef struct {
        string       req;
        logic [3:0]  stb;
        logic [31:0] wd;
        logic        err;
        logic [31:0] rd;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rd_model = '0;
    bit          done = 0;

    function automatic logic [31:0] lane_bits(logic [3:0] am);
        logic [31:0] m = '0;
        for (int l = 0; l < 4; l++) if (am[l]) m[(3-l)*8 +: 8] = 8'hFF;
        return m;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic drive(input string req, input bit act, input bit wr,
                         input logic [1:0] sz, input logic [1:0] off,
                         input bit um, input logic [3:0] mn,
                         input logic [31:0] op, input logic [31:0] bs,
                         input bit ak);
        item_t       it;
        logic [3:0]  am = '0;
        logic [31:0] wd = '0;
        logic [31:0] rx = '0;
        logic        er = 1'b0;
        @(negedge clk);
        xfer_act = act; xfer_wr = wr; size_code = sz; addr_lo = off;
        use_mask = um; lane_mask_n = mn; wr_operand = op; bus_rd = bs; ack = ak;
        if (act) begin
            if (um) begin
                am = ~mn; wd = op & lane_bits(am); rx = bs & lane_bits(am);
            end else if (sz == 2'b00 || sz == 2'b11) begin
                am = 4'hF; wd = op; rx = bs;
            end else if (sz == 2'b01) begin
                am = 4'b0001 << off;
                wd = {24'h0, op[7:0]} << (8 * (3 - int'(off)));
                rx = (bs >> (8 * (3 - int'(off)))) & 32'hFF;
            end else if (off == 2'd3) begin
                er = 1'b1;
            end else begin
                am = 4'b0011 << off;
                wd = {16'h0, op[15:0]} << (8 * (2 - int'(off)));
                rx = (bs >> (8 * (2 - int'(off)))) & 32'hFFFF;
            end
        end
        it.req = req; it.stb = ~am; it.wd = wd; it.err = er; it.rd = rd_model;
        sb_q.push_back(it);
        if (act && !wr && ak) rd_model = rx;
    endtask

    task automatic idle(input string req);
        drive(req, 0, 0, 2'b00, 2'b00, 0, 4'hF, 32'hDEADBEEF, 32'h0, 0);
    endtask

    // Monitor: pops expected items and compares them away from the edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #5;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (lane_stb_n !== it.stb || bus_wr !== it.wd ||
                    size_err !== it.err || rd_operand !== it.rd) begin
                    errors++;
                    $display("FAIL %s: stb=%b wd=%h err=%b rd=%h expected stb=%b wd=%h err=%b rd=%h",
                             it.req, lane_stb_n, bus_wr, size_err, rd_operand,
                             it.stb, it.wd, it.err, it.rd);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_model = '0;
        idle("R10 R7 reset state");

        // Long word and line, every offset
        for (int o = 0; o < 4; o++) begin
            drive("R1 long write", 1, 1, 2'b00, 2'(o), 0, 4'hF, 32'h11223344, 32'h0, 0);
            drive("R2 line write", 1, 1, 2'b11, 2'(o), 0, 4'hF, 32'hA1B2C3D4, 32'h0, 0);
        end
        // Bytes at each offset
        for (int o = 0; o < 4; o++)
            drive("R3 byte write", 1, 1, 2'b01, 2'(o), 0, 4'hF, 32'hAABBCCDD, 32'h0, 0);
        drive("R4 word write off0", 1, 1, 2'b10, 2'd0, 0, 4'hF, 32'h99887766, 32'h0, 0);
        drive("R4 word write off2", 1, 1, 2'b10, 2'd2, 0, 4'hF, 32'h99887766, 32'h0, 0);
        drive("R5 word write off1", 1, 1, 2'b10, 2'd1, 0, 4'hF, 32'h99887766, 32'h0, 0);
        drive("R6 word write off3", 1, 1, 2'b10, 2'd3, 0, 4'hF, 32'h99887766, 32'h0, 0);
        idle("R7 idle after error");

        // Reads
        drive("R8 long read", 1, 0, 2'b00, 2'd2, 0, 4'hF, 32'h0, 32'h8899AABB, 1);
        idle("R8 R9 long read captured");
        for (int o = 0; o < 4; o++) begin
            drive("R8 byte read", 1, 0, 2'b01, 2'(o), 0, 4'hF, 32'h0, 32'h12345678, 1);
            idle("R8 byte read captured");
        end
        for (int o = 0; o < 3; o++) begin
            drive("R8 word read", 1, 0, 2'b10, 2'(o), 0, 4'hF, 32'h0, 32'hCAFEF00D, 1);
            idle("R8 word read captured");
        end
        drive("R2 line read", 1, 0, 2'b11, 2'd1, 0, 4'hF, 32'h0, 32'h0BADF00D, 1);
        idle("R2 line read captured");
        drive("R9 read no ack", 1, 0, 2'b00, 2'd0, 0, 4'hF, 32'h0, 32'h55555555, 0);
        drive("R9 ack during write", 1, 1, 2'b00, 2'd0, 0, 4'hF, 32'h0, 32'h66666666, 1);
        drive("R9 ack while idle", 0, 0, 2'b00, 2'd0, 0, 4'hF, 32'h0, 32'h77777777, 1);
        idle("R9 held");
        drive("R6 bad word read", 1, 0, 2'b10, 2'd3, 0, 4'hF, 32'h0, 32'hFFFFFFFF, 1);
        idle("R6 bad word read captured zero");

        // Mask mode
        drive("R11 mask write gaps", 1, 1, 2'b01, 2'd3, 1, 4'b0101, 32'h01234567, 32'h0, 0);
        drive("R11 mask write single", 1, 1, 2'b10, 2'd3, 1, 4'b1101, 32'h01234567, 32'h0, 0);
        drive("R11 mask read", 1, 0, 2'b01, 2'd0, 1, 4'b1010, 32'h0, 32'h89ABCDEF, 1);
        idle("R11 mask read captured");

        // Reset in the middle of a run
        drive("R8 load before reset", 1, 0, 2'b00, 2'd0, 0, 4'hF, 32'h0, 32'h3C3C3C3C, 1);
        idle("R8 loaded");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_model = '0;
        idle("R10 cleared by reset");

        @(negedge clk);
        #10;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule